// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block puts a small 8-bit microcontroller core into low-power sleep and brings it back. A one-cycle sleep strobe from the core moves the block from running to sleeping. The block then stops the main oscillator and the timer/counter clocks. The exception is an ADC conversion already in progress: in that case every clock keeps running. On entry the block also sends a one-cycle clear to the watchdog, which stays enabled and keeps counting.

While asleep the block watches four wake events. Two of them, an external reset request and a watchdog expiry, restart the core through a reset request. The other two, a port input change and an ADC-done, let execution continue. The snapshot taken at sleep entry decides which events are armed. If the watchdog is enabled, both continuation events are disarmed.

A continuation wake resumes at an interrupt vector when global interrupts were enabled at entry. Otherwise it resumes at the address following the sleep instruction. Before handing control back, the block waits an oscillator start-up delay chosen by the oscillator mode. It then emits a single-cycle completion pulse that carries the cause code and the resume address. It also updates two flags that software reads to learn how the core woke.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While rst_ni is low, and on the cycles after it rises, osc_en_o is 1, every tmr_en_o bit is 1, and the following are 0: wdt_clr_o, core_rst_o, wake_done_o, flag_to_o and flag_pd_o.
- R2: A sleep_i pulse in the running state with adc_busy_i low drives osc_en_o and all tmr_en_o bits to 0 from the next cycle until a wake event is taken. wdt_clr_o is 1 for exactly that first sleeping cycle. osc_en_o returns to 1 the cycle after the edge that samples the wake event. tmr_en_o returns to all ones at wake_done_o.
- R3: When adc_busy_i is 1 at the sleep_i pulse, osc_en_o and all tmr_en_o bits stay 1 through the whole sleep. wdt_clr_o still pulses once.
- R4: Arming is taken from the inputs at sleep entry. ext_reset_i always wakes. wdt_timeout_i wakes only if wdt_en_i was 1. port_change_i wakes only if port_wake_en_i was 1 and wdt_en_i was 0. adc_done_i wakes only if adc_wake_en_i was 1 and wdt_en_i was 0. An unarmed event leaves osc_en_o at 0 and the block asleep.
- R5: When several armed events share a cycle, the cause is the highest-priority one. wake_cause_o encodes the cause as 0 for external reset, 1 for watchdog, 2 for port change and 3 for ADC done, and lower codes win.
- R6: For causes 0 and 1, core_rst_o is 1 from the cycle after the sampling edge until the start-up delay ends. It is 0 while wake_done_o is 1, and resume_pc_o is 0 then.
- R7: For causes 2 and 3, resume_pc_o at wake_done_o is 0x06 (port) or 0x0C (ADC) if gie_i was 1 at entry. If gie_i was 0, it is the next_pc_i value captured at entry.
- R8: From the wake_done_o cycle, flag_to_o equals (cause == 1) and flag_pd_o is 1. Both hold until the next wake completes.
- R9: In osc_mode_i 0 (RC), or the unused code 3, wake_done_o is visible 33 edges after the edge that samples the wake event.
- R10: In osc_mode_i 1 the delay counts N1 = HXT_MS*1000/REF_TICK_US ref_tick_i pulses. The pulses are those sampled at later edges, and t is the edge that samples the last of them. wake_done_o is then visible after edge t+33. In osc_mode_i 2 it counts N2 = LXT_MS*1000/REF_TICK_US pulses and wake_done_o is visible after edge t+1.
- R11: wake_done_o is a single-cycle pulse, after which the block runs again. Wake events outside sleep and sleep_i outside the running state have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Free-running reference tick, one pulse every REF_TICK_US microseconds |
| sleep_i | input | 1 | Sleep-instruction strobe |
| next_pc_i | input | ADDR_W | Address after the sleep instruction |
| gie_i | input | 1 | Global interrupt enable state |
| wdt_en_i | input | 1 | Watchdog enabled |
| port_wake_en_i | input | 1 | Port-change wake enable |
| adc_wake_en_i | input | 1 | ADC-done wake enable |
| adc_busy_i | input | 1 | ADC conversion in progress |
| osc_mode_i | input | 2 | 0 RC, 1 high-frequency crystal, 2 low-frequency crystal, 3 treated as RC |
| ext_reset_i | input | 1 | External reset wake request |
| wdt_timeout_i | input | 1 | Watchdog expiry |
| port_change_i | input | 1 | Port input change |
| adc_done_i | input | 1 | ADC conversion complete |
| osc_en_o | output | 1 | Main oscillator enable |
| tmr_en_o | output | NUM_TMR | Timer/counter clock enables |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| core_rst_o | output | 1 | Core reset request |
| flag_to_o | output | 1 | Last wake was a watchdog expiry |
| flag_pd_o | output | 1 | A wake from sleep has completed |
| wake_done_o | output | 1 | Single-cycle wake completion |
| wake_cause_o | output | 2 | Cause code, valid with wake_done_o |
| resume_pc_o | output | ADDR_W | Resume address, valid with wake_done_o |

## Verification
The properties assume that osc_mode_i and ref_tick_i are well behaved: osc_mode_i stays fixed from sleep entry until the completion pulse, and ref_tick_i is a one-cycle pulse. The stimulus keeps to this by setting the mode only together with the sleep strobe and by driving the tick from a fixed-period divider. Cause and resume address are only claimed while the completion pulse is high. The stimulus changes every input half a cycle away from the sampling edge, so each wake event is taken at a known edge.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_STARTUP  = 2'd2,
    ST_RELEASE  = 2'd3
  } swc_state_e;

  // lower code wins arbitration
  typedef enum logic [1:0] {
    CAUSE_EXT  = 2'd0,
    CAUSE_WDT  = 2'd1,
    CAUSE_PORT = 2'd2,
    CAUSE_ADC  = 2'd3
  } swc_cause_e;

  typedef enum logic [1:0] {
    OSC_RC   = 2'd0,
    OSC_HXT  = 2'd1,
    OSC_LXT  = 2'd2,
    OSC_RSVD = 2'd3
  } swc_osc_e;

  // configuration captured when sleep is entered
  typedef struct packed {
    logic keep_clk;
    logic arm_wdt;
    logic arm_port;
    logic arm_adc;
    logic gie;
  } swc_cfg_t;

endpackage

// File: rtl/swc_rst_sync.sv
module swc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/swc_wake_arb.sv
module swc_wake_arb
  import swc_pkg::*;
(
  input  logic       ext_i,
  input  logic       wdt_i,
  input  logic       port_i,
  input  logic       adc_i,
  input  swc_cfg_t   cfg_i,
  output logic       hit_o,
  output swc_cause_e cause_o
);
  logic [3:0] req;

  // index equals cause code
  assign req = {adc_i  & cfg_i.arm_adc,
                port_i & cfg_i.arm_port,
                wdt_i  & cfg_i.arm_wdt,
                ext_i};

  always_comb begin
    hit_o   = |req;
    cause_o = CAUSE_ADC;
    if (req[0])      cause_o = CAUSE_EXT;
    else if (req[1]) cause_o = CAUSE_WDT;
    else if (req[2]) cause_o = CAUSE_PORT;
  end
endmodule

// File: rtl/swc_startup_timer.sv
module swc_startup_timer
  import swc_pkg::*;
#(
  parameter int unsigned CLK_CYC     = 32,
  parameter int unsigned REF_TICK_US = 100,
  parameter int unsigned HXT_MS      = 2,
  parameter int unsigned LXT_MS      = 500
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     tick_i,
  input  swc_osc_e mode_i,
  output logic     done_o
);
  localparam int unsigned HXT_TICKS = (HXT_MS * 1000) / REF_TICK_US;
  localparam int unsigned LXT_TICKS = (LXT_MS * 1000) / REF_TICK_US;
  localparam int unsigned MAX_TICKS = (HXT_TICKS > LXT_TICKS) ? HXT_TICKS : LXT_TICKS;
  localparam int unsigned TW        = $clog2(MAX_TICKS + 2);
  localparam int unsigned CW        = $clog2(CLK_CYC + 2);

  logic [TW-1:0] tick_cnt_q, tick_cnt_d, tick_goal;
  logic [CW-1:0] clk_cnt_q, clk_cnt_d;
  logic          use_clk, ms_done, clk_done;

  always_comb begin
    unique case (mode_i)
      OSC_HXT: tick_goal = TW'(HXT_TICKS);
      OSC_LXT: tick_goal = TW'(LXT_TICKS);
      default: tick_goal = '0;
    endcase
  end

  assign use_clk  = (mode_i != OSC_LXT);
  assign ms_done  = (tick_cnt_q >= tick_goal);
  assign clk_done = (clk_cnt_q == CW'(CLK_CYC));
  assign done_o   = ms_done & (~use_clk | clk_done);

  always_comb begin
    tick_cnt_d = tick_cnt_q;
    clk_cnt_d  = clk_cnt_q;
    if (!run_i) begin
      tick_cnt_d = '0;
      clk_cnt_d  = '0;
    end else begin
      if (tick_i && !ms_done)            tick_cnt_d = tick_cnt_q + 1'b1;
      if (ms_done && use_clk && !clk_done) clk_cnt_d = clk_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      clk_cnt_q  <= '0;
    end else begin
      tick_cnt_q <= tick_cnt_d;
      clk_cnt_q  <= clk_cnt_d;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned NUM_TMR     = 4,
  parameter int unsigned CLK_CYC     = 32,
  parameter int unsigned REF_TICK_US = 100,
  parameter int unsigned HXT_MS      = 2,
  parameter int unsigned LXT_MS      = 500,
  parameter int unsigned RESET_VEC   = 0,
  parameter int unsigned PORT_VEC    = 6,
  parameter int unsigned ADC_VEC     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic              gie_i,
  input  logic              wdt_en_i,
  input  logic              port_wake_en_i,
  input  logic              adc_wake_en_i,
  input  logic              adc_busy_i,
  input  logic [1:0]        osc_mode_i,
  input  logic              ext_reset_i,
  input  logic              wdt_timeout_i,
  input  logic              port_change_i,
  input  logic              adc_done_i,
  output logic              osc_en_o,
  output logic [NUM_TMR-1:0] tmr_en_o,
  output logic              wdt_clr_o,
  output logic              core_rst_o,
  output logic              flag_to_o,
  output logic              flag_pd_o,
  output logic              wake_done_o,
  output logic [1:0]        wake_cause_o,
  output logic [ADDR_W-1:0] resume_pc_o
);
  logic rst_n_s;

  swc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  swc_state_e        state_q, state_d;
  swc_cfg_t          cfg_q, cfg_d;
  logic [ADDR_W-1:0] next_pc_q;
  swc_cause_e        cause_q, cause_d;
  logic              wdt_clr_q;
  logic              flag_to_q, flag_pd_q;

  logic cfg_en, cause_en, flag_en;
  logic hit, tmr_done, clk_gated, reset_type;

  // ---------------- wake arbitration ----------------
  swc_wake_arb u_arb (
    .ext_i   (ext_reset_i),
    .wdt_i   (wdt_timeout_i),
    .port_i  (port_change_i),
    .adc_i   (adc_done_i),
    .cfg_i   (cfg_q),
    .hit_o   (hit),
    .cause_o (cause_d)
  );

  // ---------------- start-up delay ----------------
  swc_startup_timer #(
    .CLK_CYC     (CLK_CYC),
    .REF_TICK_US (REF_TICK_US),
    .HXT_MS      (HXT_MS),
    .LXT_MS      (LXT_MS)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (state_q == ST_STARTUP),
    .tick_i (ref_tick_i),
    .mode_i (swc_osc_e'(osc_mode_i)),
    .done_o (tmr_done)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (sleep_i)  state_d = ST_SLEEP;
      ST_SLEEP:   if (hit)      state_d = ST_STARTUP;
      ST_STARTUP: if (tmr_done) state_d = ST_RELEASE;
      default:                  state_d = ST_RUN;
    endcase
  end

  assign cfg_en   = (state_q == ST_RUN) & sleep_i;
  assign cause_en = (state_q == ST_SLEEP) & hit;
  assign flag_en  = (state_q == ST_STARTUP) & tmr_done;

  always_comb begin
    cfg_d.keep_clk = adc_busy_i;
    cfg_d.arm_wdt  = wdt_en_i;
    cfg_d.arm_port = port_wake_en_i & ~wdt_en_i;
    cfg_d.arm_adc  = adc_wake_en_i  & ~wdt_en_i;
    cfg_d.gie      = gie_i;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_RUN;
      cfg_q     <= '0;
      next_pc_q <= '0;
      cause_q   <= CAUSE_EXT;
      wdt_clr_q <= 1'b0;
      flag_to_q <= 1'b0;
      flag_pd_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wdt_clr_q <= cfg_en;
      if (cfg_en) begin
        cfg_q     <= cfg_d;
        next_pc_q <= next_pc_i;
      end
      if (cause_en) cause_q <= cause_d;
      if (flag_en) begin
        flag_to_q <= (cause_q == CAUSE_WDT);
        flag_pd_q <= 1'b1;
      end
    end
  end

  // ---------------- outputs ----------------
  assign reset_type = (cause_q == CAUSE_EXT) | (cause_q == CAUSE_WDT);
  assign clk_gated  = ~cfg_q.keep_clk &
                      ((state_q == ST_SLEEP) | (state_q == ST_STARTUP));

  assign osc_en_o = ~(~cfg_q.keep_clk & (state_q == ST_SLEEP));

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr_en
    assign tmr_en_o[g] = ~clk_gated;
  end

  always_comb begin
    if (reset_type)
      resume_pc_o = ADDR_W'(RESET_VEC);
    else if (!cfg_q.gie)
      resume_pc_o = next_pc_q;
    else if (cause_q == CAUSE_PORT)
      resume_pc_o = ADDR_W'(PORT_VEC);
    else
      resume_pc_o = ADDR_W'(ADC_VEC);
  end

  assign wdt_clr_o    = wdt_clr_q;
  assign core_rst_o   = (state_q == ST_STARTUP) & reset_type;
  assign wake_done_o  = (state_q == ST_RELEASE);
  assign wake_cause_o = cause_q;
  assign flag_to_o    = flag_to_q;
  assign flag_pd_o    = flag_pd_q;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_TMR = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sleep_i,
  input logic               osc_en_o,
  input logic [NUM_TMR-1:0] tmr_en_o,
  input logic               wdt_clr_o,
  input logic               core_rst_o,
  input logic               flag_to_o,
  input logic               flag_pd_o,
  input logic               wake_done_o,
  input logic [1:0]         wake_cause_o,
  input logic [ADDR_W-1:0]  resume_pc_o
);
  AST_GATE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (tmr_en_o == '0)); // R2

  AST_CLEAR_NEEDS_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |-> $past(sleep_i)); // R3

  AST_CLEAR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !wake_done_o); // R11

  AST_RESET_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_done_o && wake_cause_o < 2'd2) |-> (resume_pc_o == '0)); // R6

  AST_RST_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> !core_rst_o); // R6

  AST_FLAGS_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> (flag_pd_o && (flag_to_o == (wake_cause_o == 2'd1)))); // R8

  AST_CLOCKS_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> (osc_en_o && (tmr_en_o == '1))); // R2
endmodule

bind sleep_wake_ctrl swc_checker #(
  .ADDR_W  (ADDR_W),
  .NUM_TMR (NUM_TMR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_i      (sleep_i),
  .osc_en_o     (osc_en_o),
  .tmr_en_o     (tmr_en_o),
  .wdt_clr_o    (wdt_clr_o),
  .core_rst_o   (core_rst_o),
  .flag_to_o    (flag_to_o),
  .flag_pd_o    (flag_pd_o),
  .wake_done_o  (wake_done_o),
  .wake_cause_o (wake_cause_o),
  .resume_pc_o  (resume_pc_o)
);

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TP         = 4;     // ref tick period in clocks
  localparam int ADDR_W     = 10;
  localparam int NUM_TMR    = 4;
  localparam int HXT_N      = 2;     // 2 ms / 1000 us
  localparam int LXT_N      = 50;    // 50 ms / 1000 us

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n, ref_tick, sleep, gie, wdt_en, pen, aen, busy;
  logic [ADDR_W-1:0] npc;
  logic [1:0]        mode;
  logic              ev_ext, ev_wdt, ev_port, ev_adc;
  logic              osc_en, wdt_clr, core_rst, flag_to, flag_pd, wake_done;
  logic [NUM_TMR-1:0] tmr_en;
  logic [1:0]        cause;
  logic [ADDR_W-1:0] rpc;

  sleep_wake_ctrl #(
    .ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR), .CLK_CYC(32),
    .REF_TICK_US(1000), .HXT_MS(2), .LXT_MS(50)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .sleep_i(sleep),
    .next_pc_i(npc), .gie_i(gie), .wdt_en_i(wdt_en), .port_wake_en_i(pen),
    .adc_wake_en_i(aen), .adc_busy_i(busy), .osc_mode_i(mode),
    .ext_reset_i(ev_ext), .wdt_timeout_i(ev_wdt), .port_change_i(ev_port),
    .adc_done_i(ev_adc), .osc_en_o(osc_en), .tmr_en_o(tmr_en),
    .wdt_clr_o(wdt_clr), .core_rst_o(core_rst), .flag_to_o(flag_to),
    .flag_pd_o(flag_pd), .wake_done_o(wake_done), .wake_cause_o(cause),
    .resume_pc_o(rpc)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  always @(posedge clk) cyc <= cyc + 1;
  initial ref_tick = 1'b0;
  always @(negedge clk) ref_tick <= ((cyc + 1) % TP == 0);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int exp_edge(input int m, input int e);
    int t;
    if (m == 1) begin t = (e / TP + HXT_N) * TP; return t + 33; end
    if (m == 2) begin t = (e / TP + LXT_N) * TP; return t + 1; end
    return e + 33;
  endfunction

  task automatic enter_sleep(input bit g, input bit w, input bit p, input bit a,
                             input bit b, input int pc, input int m);
    @(negedge clk);
    gie = g; wdt_en = w; pen = p; aen = a; busy = b;
    npc = ADDR_W'(pc); mode = 2'(m); sleep = 1'b1;
    @(negedge clk);
    sleep = 1'b0; npc = '0;  // R7: later changes must not matter
    chk("R2", "wdt_clr on entry", wdt_clr, 1);
    chk(b ? "R3" : "R2", "osc_en asleep", osc_en, b);
    chk(b ? "R3" : "R2", "tmr_en asleep", tmr_en, b ? 4'hF : 4'h0);
    @(negedge clk);
    chk("R2", "wdt_clr one cycle", wdt_clr, 0);
  endtask

  task automatic fire(input bit x, input bit w, input bit p, input bit a, output int e);
    @(negedge clk);
    ev_ext = x; ev_wdt = w; ev_port = p; ev_adc = a;
    e = cyc + 1;
    @(negedge clk);
    ev_ext = 0; ev_wdt = 0; ev_port = 0; ev_adc = 0;
  endtask

  task automatic finish_wake(input int e, input int m, input int ec, input int epc);
    int n = 0;
    bit rst_exp = (ec < 2);
    chk("R6", "core_rst after wake edge", core_rst, rst_exp);
    chk("R2", "osc_en after wake edge", osc_en, 1);
    while (wake_done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R11", "wake_done seen", wake_done, 1);
    chk((m == 1 || m == 2) ? "R10" : "R9", "release edge", cyc, exp_edge(m, e));
    chk("R5", "cause", cause, ec);
    chk(ec < 2 ? "R6" : "R7", "resume pc", rpc, epc);
    chk("R6", "core_rst at done", core_rst, 0);
    chk("R8", "flag_to", flag_to, ec == 1);
    chk("R8", "flag_pd", flag_pd, 1);
    chk("R2", "tmr_en at done", tmr_en, 4'hF);
    @(negedge clk);
    chk("R11", "wake_done single", wake_done, 0);
  endtask

  function automatic int pc_for(input int c, input bit g, input int np);
    if (c < 2) return 0;
    if (!g)    return np;
    return (c == 2) ? 6 : 12;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    int e;
    rst_n = 0; sleep = 0; gie = 0; wdt_en = 0; pen = 0; aen = 0; busy = 0;
    npc = '0; mode = 0; ev_ext = 0; ev_wdt = 0; ev_port = 0; ev_adc = 0;
    repeat (3) @(negedge clk);
    chk("R1", "osc_en in reset", osc_en, 1);
    chk("R1", "tmr_en in reset", tmr_en, 4'hF);
    chk("R1", "wake_done in reset", wake_done, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "tmr_en", tmr_en, 4'hF);
    chk("R1", "wdt_clr", wdt_clr, 0);
    chk("R1", "core_rst", core_rst, 0);
    chk("R1", "flags", {flag_to, flag_pd}, 0);
    chk("R1", "wake_done", wake_done, 0);

    // R11: events while running are ignored
    fire(1, 1, 1, 1, e);
    repeat (40) begin
      @(negedge clk);
      if (wake_done || core_rst || !osc_en) begin
        chk("R11", "run-state event ignored", {wake_done, core_rst, osc_en}, 3'b001);
      end
    end
    chk("R11", "still running", osc_en, 1);

    // R4 R5 R6 R7 R9: sweep of event masks, watchdog enable and gie in RC mode
    for (int w = 0; w < 2; w++) begin
      for (int g = 0; g < 2; g++) begin
        for (int mask = 1; mask < 16; mask++) begin
          bit [3:0] armed;
          int ec, np;
          np = 16'h40 + mask + 16 * g + 32 * w;
          armed = {mask[3] & ~w[0], mask[2] & ~w[0], mask[1] & w[0], mask[0]};
          enter_sleep(g[0], w[0], 1, 1, 0, np, (mask == 7) ? 3 : 0);
          if (armed == 0) begin
            fire(mask[0], mask[1], mask[2], mask[3], e);
            repeat (3) @(negedge clk);
            chk("R4", "unarmed event ignored", osc_en, 0);
            fire(1, 0, 0, 0, e);
            finish_wake(e, 0, 0, 0);
          end else begin
            ec = armed[0] ? 0 : armed[1] ? 1 : armed[2] ? 2 : 3;
            fire(mask[0], mask[1], mask[2], mask[3], e);
            finish_wake(e, (mask == 7) ? 3 : 0, ec, pc_for(ec, g[0], np));
          end
        end
      end
    end

    // R4: continuation enables off, watchdog off
    enter_sleep(1, 0, 0, 0, 0, 33, 0);
    fire(0, 1, 1, 1, e);
    repeat (3) @(negedge clk);
    chk("R4", "disabled wakes ignored", osc_en, 0);
    fire(0, 0, 0, 1, e);
    repeat (2) @(negedge clk);
    chk("R4", "adc wake disabled", osc_en, 0);
    fire(1, 0, 0, 0, e);
    finish_wake(e, 0, 0, 0);

    // R8: flags hold between wakes
    enter_sleep(0, 1, 0, 0, 0, 5, 0);
    fire(0, 1, 0, 0, e);
    finish_wake(e, 0, 1, 0);
    repeat (5) @(negedge clk);
    chk("R8", "flag_to held", flag_to, 1);

    // R3: clocks kept during ADC conversion
    enter_sleep(1, 0, 0, 1, 1, 9, 0);
    repeat (4) @(negedge clk);
    chk("R3", "osc kept", osc_en, 1);
    chk("R3", "timers kept", tmr_en, 4'hF);
    fire(0, 0, 0, 1, e);
    finish_wake(e, 0, 3, 12);

    // R10: crystal modes over every tick phase
    for (int m = 1; m < 3; m++) begin
      for (int ph = 0; ph < TP; ph++) begin
        enter_sleep(1, 0, 1, 0, 0, 17, m);
        repeat (ph) @(negedge clk);
        fire(0, 0, 1, 0, e);
        finish_wake(e, m, 2, 6);
      end
    end

    // R11: sleep strobe during start-up ignored
    enter_sleep(0, 0, 1, 0, 0, 21, 0);
    fire(0, 0, 1, 0, e);
    sleep = 1'b1;
    @(negedge clk);
    sleep = 1'b0;
    finish_wake(e, 0, 2, 21);
    repeat (3) @(negedge clk);
    chk("R11", "running after stray sleep", osc_en, 1);
    chk("R11", "no clear from stray sleep", wdt_clr, 0);

    report();
    $finish;
  end
endmodule